// File: doc/BRIEF.md
# I2C Serial Memory Read Engine

This block is the target side of a two-wire serial bus in front of a byte-wide memory array of 2^ADDR_W locations. The default is 8192 bytes. It samples the clock and data lines and drives the data line in open-drain style: `sdaOe` high pulls the line low. It recognises start, repeated start and stop conditions and answers its own 7-bit device identifier. It serves three kinds of read: a read that continues from the stored address, a random read that first loads a new address through a write header, and a sequential read that streams bytes for as long as the controller acknowledges.

The block keeps an address counter between transactions. The counter always points one past the byte most recently handed out. It is loaded by a write header carrying two word-address bytes, high byte first, and it wraps from the top of the array to 0. The array sits outside the block. The block places the counter on `memAddr` and expects the byte at that address on `memData` in the same cycle, as an asynchronous read. Programming the array is not part of this block.

Top module: `i2c_rd_engine`

## Requirements
- R1: A start is data falling while the clock is high, and a stop is data rising while the clock is high. Either condition, seen in any state, releases `sdaOe` on the next cycle. A stop returns the block to idle. A start begins reception of a new header, and an address phase that was cut short leaves the counter unchanged.
- R2: A header is 7 identifier bits followed by a direction bit, sent MSB first. Direction 1 means read and direction 0 means write. On a match the block pulls data low during the ninth clock.
- R3: A header with a different identifier is not acknowledged. The block leaves data released until the next start and does not change the counter.
- R4: After a matching write header, the block receives two word-address bytes, high byte first, and acknowledges each one. Only the low ADDR_W-8 bits of the high byte are kept. The counter is loaded once the low byte is complete.
- R5: A repeated start and a read header that follow an address load return the byte at the loaded address first.
- R6: A read header that has no address phase before it returns the byte at the current counter value. The counter persists across stops, so after a byte at N has been sent, the next such read returns N+1.
- R7: Data bytes leave MSB first. The block changes `sdaOe` only while the clock is low, except for the release on start or stop.
- R8: Each byte handed out advances the counter by one. If the controller acknowledges the ninth bit, the block sends the next byte without a pause.
- R9: Advancing past the last location (8191 by default) wraps the counter to 0, and output continues.
- R10: A not-acknowledge on the ninth bit ends the read. Data stays released through further clocks until a start or stop, and the counter keeps its advanced value.
- R11: After reset the counter is 0 and `sdaOe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | Pull-down enable for the data line |
| memAddr | output | ADDR_W | Current address counter, read address of the array |
| memData | input | 8 | Array byte at `memAddr`, asynchronous read |

## Verification
The bench builds the engine with ADDR_W = 13, device identifier 0x50 and two synchroniser stages. At that size a random read placed at 0x1FFE can walk across the top of the array and back to 0 within four bytes. High address bytes with their top three bits set show that those bits are dropped. Random transactions pick addresses anywhere in the 8192-byte space and stream one to four bytes each. A neighbouring identifier, 0x51, is used to check that a header which does not match is ignored.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_AHI,
    ST_ACK_HI,
    ST_ALO,
    ST_ACK_LO,
    ST_TX,
    ST_RX_ACK,
    ST_IGNORE
  } busState_t;

  // bus events decoded by the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } busEvt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic hiLoad;
    logic addrLoad;
    logic txLoad;
    logic txShift;
    logic ackOn;
    logic busRel;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_rd_datapath.sv
module i2c_rd_datapath
  import i2c_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter logic [6:0]  DEV_ID      = 7'h50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  input  logic [7:0]        memData,
  output busEvt_t           evt,
  output logic              sdaNow,
  output logic              devMatch,
  output logic              rwBit,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int unsigned HI_W   = ADDR_W - 8;
  localparam int unsigned PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;
  logic              sclCur;
  logic              sclOld;
  logic              sdaCur;
  logic              sdaOld;
  logic [7:0]        rxReg;
  logic [7:0]        txReg;
  logic [HI_W-1:0]   hiReg;
  logic [ADDR_W-1:0] addrCnt;
  logic              oeReg;

  // idle bus reads high, so reset the pipes to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclCur = sclPipe[SYNC_STAGES-1];
  assign sclOld = sclPipe[SYNC_STAGES];
  assign sdaCur = sdaPipe[SYNC_STAGES-1];
  assign sdaOld = sdaPipe[SYNC_STAGES];

  assign evt.sclRise   = sclCur & ~sclOld;
  assign evt.sclFall   = ~sclCur & sclOld;
  assign evt.startSeen = sclCur & sclOld & sdaOld & ~sdaCur;
  assign evt.stopSeen  = sclCur & sclOld & ~sdaOld & sdaCur;
  assign sdaNow        = sdaCur;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      hiReg <= '0;
    end else begin
      if (strb.rxShift) rxReg <= {rxReg[6:0], sdaCur};
      if (strb.hiLoad)  hiReg <= rxReg[HI_W-1:0];
    end
  end

  assign devMatch = (rxReg[7:1] == DEV_ID);
  assign rwBit    = rxReg[0];

  // persistent address counter, wraps at 2^ADDR_W
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrCnt <= '0;
    else if (strb.addrLoad) addrCnt <= {hiReg, rxReg};
    else if (strb.txLoad)   addrCnt <= addrCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txReg <= '0;
    else if (strb.txLoad)  txReg <= memData;
    else if (strb.txShift) txReg <= {txReg[6:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             oeReg <= 1'b0;
    else if (strb.busRel)  oeReg <= 1'b0;
    else if (strb.ackOn)   oeReg <= 1'b1;
    else if (strb.txLoad)  oeReg <= ~memData[7];
    else if (strb.txShift) oeReg <= ~txReg[6];
  end

  assign sdaOe   = oeReg;
  assign memAddr = addrCnt;

endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEvt_t   evt,
  input  logic      sdaNow,
  input  logic      devMatch,
  input  logic      rwBit,
  output dpStrobe_t strb
);

  busState_t state;
  busState_t stateNxt;
  logic [3:0] bitCnt;
  logic [3:0] bitCntNxt;
  logic       ackSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackSeen <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
      if (state == ST_RX_ACK && evt.sclRise) ackSeen <= ~sdaNow;
    end
  end

  always_comb begin
    strb      = '0;
    stateNxt  = state;
    bitCntNxt = bitCnt;
    if (evt.stopSeen) begin
      strb.busRel = 1'b1;
      stateNxt    = ST_IDLE;
      bitCntNxt   = '0;
    end else if (evt.startSeen) begin
      strb.busRel = 1'b1;
      stateNxt    = ST_DEV;
      bitCntNxt   = '0;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (evt.sclRise && bitCnt < 4'd8) begin
            strb.rxShift = 1'b1;
            bitCntNxt    = bitCnt + 4'd1;
          end else if (evt.sclFall && bitCnt == 4'd8) begin
            bitCntNxt = '0;
            if (state == ST_DEV) begin
              if (devMatch) begin
                strb.ackOn = 1'b1;
                stateNxt   = ST_ACK_DEV;
              end else begin
                stateNxt = ST_IGNORE;
              end
            end else if (state == ST_AHI) begin
              strb.hiLoad = 1'b1;
              strb.ackOn  = 1'b1;
              stateNxt    = ST_ACK_HI;
            end else begin
              strb.addrLoad = 1'b1;
              strb.ackOn    = 1'b1;
              stateNxt      = ST_ACK_LO;
            end
          end
        end
        ST_ACK_DEV: begin
          if (evt.sclFall) begin
            if (rwBit) begin
              strb.txLoad = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              strb.busRel = 1'b1;
              stateNxt    = ST_AHI;
            end
          end
        end
        ST_ACK_HI: begin
          if (evt.sclFall) begin
            strb.busRel = 1'b1;
            stateNxt    = ST_ALO;
          end
        end
        ST_ACK_LO: begin
          if (evt.sclFall) begin
            strb.busRel = 1'b1;
            stateNxt    = ST_IGNORE;
          end
        end
        ST_TX: begin
          if (evt.sclRise) begin
            bitCntNxt = bitCnt + 4'd1;
          end else if (evt.sclFall) begin
            if (bitCnt == 4'd8) begin
              strb.busRel = 1'b1;
              bitCntNxt   = '0;
              stateNxt    = ST_RX_ACK;
            end else begin
              strb.txShift = 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (evt.sclFall) begin
            if (ackSeen) begin
              strb.txLoad = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import i2c_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter logic [6:0]  DEV_ID      = 7'h50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData
);

  busEvt_t   evt;
  dpStrobe_t strb;
  logic      sdaNow;
  logic      devMatch;
  logic      rwBit;

  i2c_rd_datapath #(
    .ADDR_W     (ADDR_W),
    .DEV_ID     (DEV_ID),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strb    (strb),
    .memData (memData),
    .evt     (evt),
    .sdaNow  (sdaNow),
    .devMatch(devMatch),
    .rwBit   (rwBit),
    .sdaOe   (sdaOe),
    .memAddr (memAddr)
  );

  i2c_rd_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .sdaNow  (sdaNow),
    .devMatch(devMatch),
    .rwBit   (rwBit),
    .strb    (strb)
  );

endmodule

// File: rtl/i2c_rd_checker.sv
module i2c_rd_checker
  import i2c_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [ADDR_W-1:0] memAddr,
  input dpStrobe_t         strb,
  input busEvt_t           evt
);

  AST_COND_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (evt.stopSeen || evt.startSeen) |=> !sdaOe); // R1

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($changed(sdaOe) && !$past(evt.stopSeen) && !$past(evt.startSeen)) |-> !sclIn); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> (memAddr == ADDR_W'($past(memAddr) + 1'b1))); // R9

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.txLoad || strb.addrLoad) |=> $stable(memAddr)); // R6

  AST_ACK_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackOn |=> sdaOe); // R2

endmodule

bind i2c_rd_engine i2c_rd_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .sclIn  (sclIn),
  .sdaOe  (sdaOe),
  .memAddr(memAddr),
  .strb   (strb),
  .evt    (evt)
);

// File: tb/i2c_rd_engine_tb_top.sv
module i2c_rd_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int ADDR_W     = 13;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic sdaBus;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] expAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memModel(logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[12:8], a[12:10]} ^ 8'h5A;
  endfunction

  assign sdaBus  = mSda & ~sdaOe;
  assign memData = memModel(memAddr);

  i2c_rd_engine #(.ADDR_W(ADDR_W), .DEV_ID(DEV), .SYNC_STAGES(2)) dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (scl),
    .sdaIn  (sdaBus),
    .sdaOe  (sdaOe),
    .memAddr(memAddr),
    .memData(memData)
  );

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ();
    scl = 1'b1;  waitQ();
    mSda = 1'b0; waitQ();
    scl = 1'b0;  waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    scl = 1'b1;  waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic writeBit(logic b);
    mSda = b; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    b = sdaBus; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic sendByte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(ack);
  endtask

  task automatic recvByte(bit ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(ackIt ? 1'b0 : 1'b1);
  endtask

  // read n bytes after an acknowledged read header, last one not acknowledged
  task automatic readBody(int n, string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, v);
      check(v == memModel(expAddr), req, v, memModel(expAddr));
      expAddr = expAddr + 1'b1;
    end
  endtask

  task automatic curRead(int n, string req);
    logic ack;
    busStart();
    sendByte({DEV, 1'b1}, ack);
    check(ack == 1'b0, "R2 read header ack", ack, 0);
    readBody(n, req);
    busStop();
  endtask

  task automatic randRead(logic [7:0] hi, logic [7:0] lo, int n, string req);
    logic ack;
    busStart();
    sendByte({DEV, 1'b0}, ack);
    check(ack == 1'b0, "R2 write header ack", ack, 0);
    sendByte(hi, ack);
    check(ack == 1'b0, "R4 high byte ack", ack, 0);
    sendByte(lo, ack);
    check(ack == 1'b0, "R4 low byte ack", ack, 0);
    expAddr = {hi[4:0], lo};
    busStart();
    sendByte({DEV, 1'b1}, ack);
    check(ack == 1'b0, "R5 read header ack", ack, 0);
    readBody(n, req);
    busStop();
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    // R11 reset state
    check(sdaOe == 1'b0, "R11 sdaOe after reset", sdaOe, 0);
    check(memAddr == '0, "R11 counter after reset", memAddr, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R6 current reads continue across stop
    curRead(1, "R6 first current read");
    curRead(2, "R6 current read after stop");

    // R4 R5 R8 random read, upper high-byte bits set
    randRead(8'hF2, 8'h34, 5, "R8 sequential from 0x1234");

    // R9 wrap at top
    randRead(8'h1F, 8'hFE, 4, "R9 wrap across 0x1FFF");
    check(expAddr == 13'd2, "R9 model counter", expAddr, 2);
    curRead(1, "R9 counter after wrap");

    // R3 other identifier
    busStart();
    sendByte({7'h51, 1'b1}, ack);
    check(ack == 1'b1, "R3 no ack for foreign id", ack, 1);
    recvByte(1'b0, v);
    check(v == 8'hFF, "R3 line released", v, 8'hFF);
    busStop();
    curRead(1, "R3 counter unchanged");

    // R1 stop during address phase
    busStart();
    sendByte({DEV, 1'b0}, ack);
    sendByte(8'h05, ack);
    busStop();
    curRead(1, "R1 stop keeps counter");

    // R1 repeated start during address phase
    busStart();
    sendByte({DEV, 1'b0}, ack);
    sendByte(8'h07, ack);
    busStart();
    sendByte({DEV, 1'b1}, ack);
    check(ack == 1'b0, "R1 header after restart", ack, 0);
    readBody(1, "R1 restart keeps counter");
    busStop();

    // R10 not-acknowledge ends output
    busStart();
    sendByte({DEV, 1'b1}, ack);
    readBody(1, "R10 byte before nack");
    recvByte(1'b0, v);
    check(v == 8'hFF, "R10 released after nack", v, 8'hFF);
    busStop();
    curRead(1, "R10 counter advanced");

    // random mix, R5 R6 R8
    void'($urandom(32'd2024));
    for (int k = 0; k < 8; k++) begin
      logic [12:0] a;
      logic [2:0]  junk;
      int n;
      a    = 13'($urandom);
      junk = 3'($urandom);
      n    = 1 + int'($urandom % 4);
      if ($urandom % 2 == 0) randRead({junk, a[12:8]}, a[7:0], n, "R5 random read");
      else curRead(n, "R8 current sequential");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule